// File: doc/BRIEF.md
# Layered Pixel Alpha Blender

A streaming compositing stage that places one foreground pixel over one background pixel on every clock. Each input pixel brings a foreground color with its own alpha, a background color from the layer beneath and a flag saying whether such a layer is connected at all. When no lower layer is connected, a programmable fill color takes the background's place. The result leaves the block a fixed number of cycles later, with a valid flag that follows the input valid. There is no backpressure.

The effective alpha comes from one of three sources: the pixel's own alpha, the pixel alpha scaled by a global gain, or a single plane alpha that ignores the pixel alpha. A separate pre-multiplied flag marks foreground color that already carries its alpha, so the foreground term is not scaled by pixel alpha a second time. With these two settings one datapath covers the usual plane blend modes. An opaque plane with no per-pixel alpha uses the plane-alpha source. Coverage blending uses either of the pixel-alpha sources with the flag clear. Pre-multiplied blending uses the same sources with the flag set. Configuration is written into a staging copy and becomes active only on a frame-start pulse, so a frame never mixes two settings.

Top module: `pixel_alpha_blender`

## Requirements
- R1: After reset, out_valid and out_rgb are 0. The active configuration is mode 0, pre-multiplied set, plane alpha 255, gain 255 and fill color 0.
- R2: Mode code 0 sets the effective alpha E to the pixel alpha.
- R3: Mode code 1 sets E to N(pixel alpha, gain), where N(x,y) = floor((x*y + 127) / 255).
- R4: Mode code 2, and the unused code 3, set E to the plane alpha. The pixel alpha then has no effect on the output.
- R5: With the pre-multiplied flag clear, each channel is N(E, fg) + N(255 - E, bg). Colors are packed red in [23:16], green in [15:8] and blue in [7:0].
- R6: With the pre-multiplied flag set, each channel is min(255, N(S, fg) + N(255 - E, bg)). The foreground scale S is 255 in mode 0, the gain in mode 1 and the plane alpha in modes 2 and 3.
- R7: When in_bg_present is 1, bg is in_bg_rgb. When it is 0, bg is the configured fill color.
- R8: A configuration write (cfg_we) changes only the staging copy. A frame_start pulse copies the staging value held before that clock edge into the active configuration. A write in the same cycle as frame_start waits for the next pulse.
- R9: out_valid equals in_valid delayed by exactly three clocks, and out_rgb belongs to the pixel given three clocks earlier.
- R10: With the pre-multiplied flag clear, E = 255 gives the foreground exactly and E = 0 gives the background exactly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Input pixel valid |
| in_fg_rgb | input | 24 | Foreground color |
| in_fg_alpha | input | 8 | Foreground pixel alpha |
| in_bg_rgb | input | 24 | Background color from the lower layer |
| in_bg_present | input | 1 | A lower layer is connected |
| cfg_we | input | 1 | Write strobe for the staging configuration |
| cfg_mode | input | 2 | Alpha source select |
| cfg_premult | input | 1 | Foreground color is pre-multiplied |
| cfg_plane_alpha | input | 8 | Plane alpha |
| cfg_gain | input | 8 | Global gain |
| cfg_bg_rgb | input | 24 | Fill color used when no lower layer is present |
| frame_start | input | 1 | Loads the staging configuration into the active one |
| out_valid | output | 1 | Output pixel valid |
| out_rgb | output | 24 | Blended color |

## Verification
The case that is hardest to reach from the ports is a configuration write racing a frame boundary. A write with no frame pulse, followed by pixels, must leave the old setting in force. A write in the same cycle as frame_start must activate the previous staging value, and the new one only at the next pulse. The bench builds this sequence on purpose, with pixels streaming between the steps. It also sweeps every alpha value under every mode and flag combination, and every gain value, so that rounding, the saturated sum and the exact pass-through at the alpha extremes are covered in full.

// File: rtl/blend_pkg.sv
package blend_pkg;
  localparam int CH_W = 8;
  localparam int N_CH = 3;
  localparam logic [CH_W-1:0] FULL = '1;

  typedef enum logic [1:0] {
    AM_PIXEL      = 2'd0,
    AM_PIXEL_GAIN = 2'd1,
    AM_PLANE      = 2'd2,
    AM_SPARE      = 2'd3
  } amode_e;

  typedef struct packed {
    amode_e               mode;
    logic                 premult;
    logic [CH_W-1:0]      plane_alpha;
    logic [CH_W-1:0]      gain;
    logic [N_CH*CH_W-1:0] fill_rgb;
  } blend_cfg_t;

  localparam blend_cfg_t CFG_RESET = '{mode: AM_PIXEL, premult: 1'b1,
                                       plane_alpha: FULL, gain: FULL,
                                       fill_rgb: '0};

  // x*y/255 rounded to nearest
  function automatic logic [CH_W-1:0] norm_mul(input logic [CH_W-1:0] x,
                                               input logic [CH_W-1:0] y);
    logic [2*CH_W:0] p;
    p = ({{(CH_W+1){1'b0}}, x} * {{(CH_W+1){1'b0}}, y})
        + (2*CH_W+1)'(FULL >> 1);
    return CH_W'(p / (2*CH_W+1)'(FULL));
  endfunction

  function automatic logic [CH_W-1:0] eff_alpha(input amode_e m,
      input logic [CH_W-1:0] pix_a, input logic [CH_W-1:0] gain,
      input logic [CH_W-1:0] plane_a);
    case (m)
      AM_PIXEL:      return pix_a;
      AM_PIXEL_GAIN: return norm_mul(pix_a, gain);
      default:       return plane_a;
    endcase
  endfunction

  // weight on the foreground color; pre-multiplied color skips pixel alpha
  function automatic logic [CH_W-1:0] fg_scale(input amode_e m,
      input logic pm, input logic [CH_W-1:0] eff,
      input logic [CH_W-1:0] gain, input logic [CH_W-1:0] plane_a);
    if (!pm) return eff;
    case (m)
      AM_PIXEL:      return FULL;
      AM_PIXEL_GAIN: return gain;
      default:       return plane_a;
    endcase
  endfunction

  function automatic logic [CH_W-1:0] sat_add(input logic [CH_W-1:0] a,
                                              input logic [CH_W-1:0] b);
    logic [CH_W:0] s;
    s = {1'b0, a} + {1'b0, b};
    return s[CH_W] ? FULL : s[CH_W-1:0];
  endfunction
endpackage

// File: rtl/blend_cfg_shadow.sv
module blend_cfg_shadow
  import blend_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       we,
  input  blend_cfg_t wr_cfg,
  input  logic       frame_start,
  output blend_cfg_t active
);
  blend_cfg_t staged;

  always_ff @(posedge clk) begin
    if (rst) begin
      staged <= CFG_RESET;
      active <= CFG_RESET;
    end else begin
      if (we) staged <= wr_cfg;
      if (frame_start) active <= staged;
    end
  end

  // R8
  cfg_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !frame_start |=> active == $past(active));
  // R8
  cfg_load_chk: assert property (@(posedge clk) disable iff (rst)
    frame_start |=> active == $past(staged));
endmodule

// File: rtl/blend_channel.sv
module blend_channel
  import blend_pkg::*;
(
  input  logic            clk,
  input  logic            rst,
  input  logic            in_v,
  input  logic [CH_W-1:0] fg,
  input  logic [CH_W-1:0] bg,
  input  logic [CH_W-1:0] fg_w,
  input  logic [CH_W-1:0] bg_w,
  output logic [CH_W-1:0] out
);
  logic [CH_W-1:0] fg_term, bg_term;

  always_ff @(posedge clk) begin
    if (rst) begin
      fg_term <= '0;
      bg_term <= '0;
      out     <= '0;
    end else begin
      if (in_v) begin
        fg_term <= norm_mul(fg_w, fg);
        bg_term <= norm_mul(bg_w, bg);
      end
      out <= sat_add(fg_term, bg_term);
    end
  end

  // R10
  fg_pass_chk: assert property (@(posedge clk) disable iff (rst)
    in_v && fg_w == FULL && bg_w == '0 |=> fg_term == $past(fg) && bg_term == '0);
  // R10
  bg_pass_chk: assert property (@(posedge clk) disable iff (rst)
    in_v && fg_w == '0 && bg_w == FULL |=> fg_term == '0 && bg_term == $past(bg));
  // R5
  zero_fg_chk: assert property (@(posedge clk) disable iff (rst)
    in_v && fg_w == '0 |=> fg_term == '0);
endmodule

// File: rtl/pixel_alpha_blender.sv
module pixel_alpha_blender
  import blend_pkg::*;
#(
  parameter int CW  = CH_W,
  parameter int NC  = N_CH,
  localparam int PW = CW * NC
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          in_valid,
  input  logic [PW-1:0] in_fg_rgb,
  input  logic [CW-1:0] in_fg_alpha,
  input  logic [PW-1:0] in_bg_rgb,
  input  logic          in_bg_present,
  input  logic          cfg_we,
  input  logic [1:0]    cfg_mode,
  input  logic          cfg_premult,
  input  logic [CW-1:0] cfg_plane_alpha,
  input  logic [CW-1:0] cfg_gain,
  input  logic [PW-1:0] cfg_bg_rgb,
  input  logic          frame_start,
  output logic          out_valid,
  output logic [PW-1:0] out_rgb
);
  blend_cfg_t wr_cfg, act;
  assign wr_cfg = '{mode: amode_e'(cfg_mode), premult: cfg_premult,
                    plane_alpha: cfg_plane_alpha, gain: cfg_gain,
                    fill_rgb: cfg_bg_rgb};

  blend_cfg_shadow u_shadow (
    .clk(clk), .rst(rst), .we(cfg_we), .wr_cfg(wr_cfg),
    .frame_start(frame_start), .active(act)
  );

  // stage 1: alpha selection and background source
  logic [CW-1:0] eff_a, fg_w;
  logic [PW-1:0] bg_sel;
  assign eff_a  = eff_alpha(act.mode, in_fg_alpha, act.gain, act.plane_alpha);
  assign fg_w   = fg_scale(act.mode, act.premult, eff_a, act.gain, act.plane_alpha);
  assign bg_sel = in_bg_present ? in_bg_rgb : act.fill_rgb;

  logic          s1_v, s2_v, s3_v;
  logic [PW-1:0] s1_fg, s1_bg;
  logic [CW-1:0] s1_fgw, s1_bgw;

  always_ff @(posedge clk) begin
    if (rst) begin
      s1_v   <= 1'b0;
      s2_v   <= 1'b0;
      s3_v   <= 1'b0;
      s1_fg  <= '0;
      s1_bg  <= '0;
      s1_fgw <= '0;
      s1_bgw <= '0;
    end else begin
      s1_v <= in_valid;
      s2_v <= s1_v;
      s3_v <= s2_v;
      if (in_valid) begin
        s1_fg  <= in_fg_rgb;
        s1_bg  <= bg_sel;
        s1_fgw <= fg_w;
        s1_bgw <= FULL - eff_a;
      end
    end
  end

  // stages 2 and 3: per-channel products, then saturated sum
  for (genvar c = 0; c < NC; c++) begin : g_ch
    blend_channel u_ch (
      .clk(clk), .rst(rst), .in_v(s1_v),
      .fg(s1_fg[c*CW +: CW]), .bg(s1_bg[c*CW +: CW]),
      .fg_w(s1_fgw), .bg_w(s1_bgw),
      .out(out_rgb[c*CW +: CW])
    );
  end

  assign out_valid = s3_v;

  // cycles since reset, saturating, for the latency check
  logic [1:0] age;
  always_ff @(posedge clk) begin
    if (rst) age <= '0;
    else if (age != 2'd3) age <= age + 2'd1;
  end

  // R9
  out_valid_latency_chk: assert property (@(posedge clk) disable iff (rst)
    age == 2'd3 |-> out_valid == $past(in_valid, 3));
  // R4
  plane_ignores_pixel_chk: assert property (@(posedge clk) disable iff (rst)
    in_valid && act.mode[1] |=> s1_bgw == FULL - $past(act.plane_alpha));
endmodule

// File: tb/tb_pixel_alpha_blender.sv
`timescale 1ns/1ps
module tb_pixel_alpha_blender;
  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic rst, in_valid, in_bg_present, cfg_we, cfg_premult, frame_start, out_valid;
  logic [23:0] in_fg_rgb, in_bg_rgb, cfg_bg_rgb, out_rgb;
  logic [7:0]  in_fg_alpha, cfg_plane_alpha, cfg_gain;
  logic [1:0]  cfg_mode;

  pixel_alpha_blender dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_fg_rgb(in_fg_rgb),
    .in_fg_alpha(in_fg_alpha), .in_bg_rgb(in_bg_rgb), .in_bg_present(in_bg_present),
    .cfg_we(cfg_we), .cfg_mode(cfg_mode), .cfg_premult(cfg_premult),
    .cfg_plane_alpha(cfg_plane_alpha), .cfg_gain(cfg_gain), .cfg_bg_rgb(cfg_bg_rgb),
    .frame_start(frame_start), .out_valid(out_valid), .out_rgb(out_rgb)
  );

  typedef struct { int mode; int pm; int pa; int gain; logic [23:0] fill; } mcfg_t;
  mcfg_t stg, act;

  int checks = 0, errors = 0;
  logic        hv [1:3];
  logic [23:0] hr [1:3];
  string       ht [1:3];

  function automatic int rn(int x, int y);
    return (2 * x * y + 255) / 510;
  endfunction

  function automatic logic [23:0] model(logic [23:0] fg, int a, logic [23:0] bg, bit pres);
    int e, s, f, b, sum;
    logic [23:0] bsel, r;
    e = (act.mode == 0) ? a : (act.mode == 1) ? rn(a, act.gain) : act.pa;
    if (act.pm == 0) s = e;
    else s = (act.mode == 0) ? 255 : (act.mode == 1) ? act.gain : act.pa;
    bsel = pres ? bg : act.fill;
    for (int c = 0; c < 3; c++) begin
      f = int'(fg[c*8 +: 8]);
      b = int'(bsel[c*8 +: 8]);
      sum = rn(s, f) + rn(255 - e, b);
      if (sum > 255) sum = 255;
      r[c*8 +: 8] = 8'(sum);
    end
    return r;
  endfunction

  task automatic cyc();
    @(negedge clk);
    if (hv[3] || out_valid) begin
      checks++;
      if (out_valid !== hv[3] || (hv[3] && out_rgb !== hr[3])) begin
        errors++;
        $display("FAIL %s: actual valid=%0b rgb=%06h expected valid=%0b rgb=%06h",
                 ht[3], out_valid, out_rgb, hv[3], hr[3]);
      end
    end
    hv[3] = hv[2]; hr[3] = hr[2]; ht[3] = ht[2];
    hv[2] = hv[1]; hr[2] = hr[1]; ht[2] = ht[1];
    hv[1] = 1'b0;
    in_valid = 1'b0; frame_start = 1'b0; cfg_we = 1'b0;
  endtask

  task automatic pix(logic [23:0] fg, int a, logic [23:0] bg, bit pres, string tag);
    cyc();
    in_valid = 1'b1; in_fg_rgb = fg; in_fg_alpha = 8'(a);
    in_bg_rgb = bg; in_bg_present = pres;
    hv[1] = 1'b1; hr[1] = model(fg, a, bg, pres); ht[1] = tag;
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) cyc();
  endtask

  task automatic write_cfg(int m, int pm, int pa, int g, logic [23:0] fill, bit with_fs);
    cyc();
    cfg_we = 1'b1; cfg_mode = 2'(m); cfg_premult = pm[0];
    cfg_plane_alpha = 8'(pa); cfg_gain = 8'(g); cfg_bg_rgb = fill;
    if (with_fs) begin frame_start = 1'b1; act = stg; end
    stg = '{m, pm, pa, g, fill};
  endtask

  task automatic frame();
    cyc();
    frame_start = 1'b1;
    act = stg;
  endtask

  task automatic sweep(string tag, int salt);
    for (int a = 0; a < 256; a++)
      pix({8'(a ^ 8'h5A), 8'(255 - a), 8'(a * 3 + salt)}, a,
          {8'(a + 40), 8'h80, 8'(~(a * 7))}, (a % 3) != 0, tag);
  endtask

  initial begin
    #(20 * 150000);
    errors++;
    $display("FAIL R9: run hung, actual no finish expected finish");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    for (int i = 1; i <= 3; i++) begin hv[i] = 1'b0; hr[i] = '0; ht[i] = ""; end
    rst = 1'b1; in_valid = 0; in_fg_rgb = 0; in_fg_alpha = 0; in_bg_rgb = 0;
    in_bg_present = 0; cfg_we = 0; cfg_mode = 0; cfg_premult = 0;
    cfg_plane_alpha = 0; cfg_gain = 0; cfg_bg_rgb = 0; frame_start = 0;
    stg = '{0, 1, 255, 255, 24'h0}; act = stg;
    repeat (3) @(negedge clk);
    checks++;
    if (out_valid !== 1'b0 || out_rgb !== 24'h0) begin
      errors++;
      $display("FAIL R1: actual valid=%0b rgb=%06h expected valid=0 rgb=000000", out_valid, out_rgb);
    end
    rst = 1'b0;

    // R1 defaults: pre-multiplied, pixel alpha, zero fill (no lower layer -> fg)
    pix(24'h123456, 77, 24'hFFFFFF, 1'b0, "R1");
    pix(24'hF0F0F0, 0, 24'h808080, 1'b1, "R1");
    sweep("R1", 5);

    // R2..R6 every mode and flag over every alpha
    write_cfg(0, 0, 100, 200, 24'h336699, 1'b0); frame(); sweep("R2", 1);
    write_cfg(1, 0, 100, 200, 24'h336699, 1'b0); frame(); sweep("R3", 2);
    write_cfg(2, 0, 100, 200, 24'h336699, 1'b0); frame(); sweep("R4", 3);
    write_cfg(3, 0, 45, 200, 24'h102030, 1'b0);  frame(); sweep("R4", 4);
    write_cfg(0, 1, 100, 200, 24'hC0C0C0, 1'b0); frame(); sweep("R6", 6);
    write_cfg(1, 1, 100, 200, 24'hC0C0C0, 1'b0); frame(); sweep("R6", 7);
    write_cfg(2, 1, 180, 200, 24'hC0C0C0, 1'b0); frame(); sweep("R6", 8);

    // R3 every gain value
    for (int g = 0; g < 256; g++) begin
      write_cfg(1, 0, 0, g, 24'h0, 1'b0); frame();
      pix(24'hE01F7C, 190, 24'h25A0D2, 1'b1, "R3");
    end

    // R4 pixel alpha has no effect under plane alpha
    write_cfg(2, 0, 128, 0, 24'h0, 1'b0); frame();
    pix(24'hFF00FF, 0, 24'h00FF00, 1'b1, "R4");
    pix(24'hFF00FF, 255, 24'h00FF00, 1'b1, "R4");

    // R5 and R10 extremes with the flag clear
    write_cfg(2, 0, 255, 0, 24'h777777, 1'b0); frame();
    pix(24'hABCDEF, 3, 24'h010203, 1'b1, "R10");
    write_cfg(2, 0, 0, 0, 24'h777777, 1'b0); frame();
    pix(24'hABCDEF, 250, 24'h010203, 1'b1, "R10");
    pix(24'hABCDEF, 250, 24'h010203, 1'b0, "R7");

    // R8 staging and frame boundary race
    write_cfg(2, 0, 255, 0, 24'h0, 1'b0); frame();      // active: fg pass
    write_cfg(2, 0, 0, 0, 24'h0, 1'b0);                 // staged: bg pass
    pix(24'h111111, 9, 24'h999999, 1'b1, "R8");         // still fg
    pix(24'h222222, 9, 24'h999999, 1'b1, "R8");
    write_cfg(2, 0, 128, 0, 24'h0, 1'b1);               // activates bg pass only
    pix(24'h333333, 9, 24'h999999, 1'b1, "R8");
    pix(24'h444444, 9, 24'h999999, 1'b1, "R8");
    frame();                                            // now half blend
    pix(24'h555555, 9, 24'hAAAAAA, 1'b1, "R8");

    // R9 bubbles between pixels
    for (int i = 0; i < 12; i++) begin
      pix(24'(i * 24'h0A0B0C), i * 20, 24'h0F0F0F, 1'b1, "R9");
      if (i % 3 == 0) idle(i % 4 + 1);
    end
    idle(6);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule